// File: doc/BRIEF.md
# Two-Cycle 8x8 Multiplier Unit

This unit sits in the execute stage of an 8-bit processor datapath and forms the 16-bit product of two byte operands. A single `start` pulse loads both operands and a two-bit mode code. The product, a zero flag and a carry flag then appear together with a one-cycle `done` strobe, a fixed two cycles later. The product is destined for one fixed register pair (high byte and low byte), so the unit never hands back a destination address. `flagWe` marks the cycle in which the status register may take the zero and carry results; it leaves every other status bit alone.

Four operand interpretations share the same datapath. Both operands can be unsigned. Both can be two's complement. Operand A can be signed while operand B is unsigned. The fourth is an unsigned fractional form that doubles the raw product. Internally each operand is extended by one bit according to the mode, so a single signed 9x9 multiplier covers all four cases.

Top module: `mul_unit`

## Requirements
- R1: A start seen at a rising edge while the unit is idle produces `done` high in the cycle that follows the second rising edge after it; `done` is low in the cycle between.
- R2: `done` is high for exactly one cycle per accepted operation, and `product`, `flagZ` and `flagC` keep their values until the next `done`.
- R3: With mode 2'd0, both operands are unsigned and `product` is their 16-bit unsigned product.
- R4: With mode 2'd1, both operands are two's complement and `product` is the 16-bit two's-complement product.
- R5: With mode 2'd2, operand A is two's complement and operand B is unsigned, and `product` is the 16-bit two's-complement product.
- R6: With mode 2'd3, both operands are unsigned and `product` is the unsigned product shifted left by one, with bit 0 cleared and bit 15 of the unshifted product dropped.
- R7: `flagC` equals bit 15 of the product before any fractional shift.
- R8: `flagZ` is 1 exactly when all 16 bits of the returned `product` are zero.
- R9: A start that arrives while an operation is in flight is ignored: the result comes from the first operands and no extra `done` follows.
- R10: `flagWe` is high exactly in the cycles in which `done` is high.
- R11: While reset is asserted, `product`, `flagZ`, `flagC`, `flagWe` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiply with the present operands and mode |
| mode | input | 2 | Operand interpretation: 0 unsigned, 1 signed, 2 signed-by-unsigned, 3 fractional unsigned |
| opA | input | 8 | First operand (the signed one in mode 2) |
| opB | input | 8 | Second operand |
| product | output | 16 | Result for the fixed register pair; bits 15:8 high byte, 7:0 low byte |
| flagZ | output | 1 | Zero flag result |
| flagC | output | 1 | Carry flag result |
| flagWe | output | 1 | Write enable for the zero and carry flags |
| done | output | 1 | One-cycle strobe marking a valid result |

## Verification
Product, both flags, `flagWe` and `done` all come from the same second register stage, so they are due together in the cycle after the second rising edge that follows the accepting edge. The bench drives `start` on a falling edge. It confirms that `done` is still low one falling edge later and takes the results on the falling edge after that, then checks on the next falling edge that the strobe has ended and the results have held. For the ignored-start case the bench holds `start` through the busy cycle with different operands and watches two more cycles for a stray `done`.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    MUL_UU   = 2'd0,
    MUL_SS   = 2'd1,
    MUL_SU   = 2'd2,
    MUL_FRAC = 2'd3
  } mulMode_e;

  typedef struct packed {
    logic capture;
    logic finish;
  } mulStrobes_t;

endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output mulStrobes_t strobes
);

  typedef enum logic {ST_IDLE = 1'b0, ST_EXEC = 1'b1} ctrlState_e;

  ctrlState_e state;
  ctrlState_e stateNext;

  always_comb begin
    stateNext       = state;
    strobes.capture = 1'b0;
    strobes.finish  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.capture = 1'b1;
          stateNext       = ST_EXEC;
        end
      end
      ST_EXEC: begin
        strobes.finish = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_ACCEPT_TO_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    (start && state == ST_IDLE) |=> strobes.finish); // R1

  AST_BUSY_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC) |=> (state == ST_IDLE && !strobes.finish)); // R9

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mulStrobes_t       strobes,
  input  logic [1:0]        mode,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [2*OP_W-1:0] product,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagWe,
  output logic              done
);

  localparam int EXT_W  = OP_W + 1;
  localparam int PROD_W = 2 * OP_W;
  localparam int FULL_W = 2 * EXT_W;

  mulMode_e modeSel;
  logic     signA;
  logic     signB;

  assign modeSel = mulMode_e'(mode);
  assign signA   = (modeSel == MUL_SS) || (modeSel == MUL_SU);
  assign signB   = (modeSel == MUL_SS);

  // stage 1: operands extended by one bit according to the mode
  logic signed [EXT_W-1:0] aQ;
  logic signed [EXT_W-1:0] bQ;
  logic                    fracQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aQ    <= '0;
      bQ    <= '0;
      fracQ <= 1'b0;
    end else if (strobes.capture) begin
      aQ    <= {signA & opA[OP_W-1], opA};
      bQ    <= {signB & opB[OP_W-1], opB};
      fracQ <= (modeSel == MUL_FRAC);
    end
  end

  // stage 2: one signed multiplier serves every mode
  logic signed [FULL_W-1:0] rawFull;
  logic [PROD_W-1:0]        raw;
  logic [PROD_W-1:0]        shaped;

  assign rawFull = aQ * bQ;
  assign raw     = rawFull[PROD_W-1:0];
  assign shaped  = fracQ ? {raw[PROD_W-2:0], 1'b0} : raw;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      product <= '0;
      flagZ   <= 1'b0;
      flagC   <= 1'b0;
      flagWe  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done   <= strobes.finish;
      flagWe <= strobes.finish;
      if (strobes.finish) begin
        product <= shaped;
        flagC   <= raw[PROD_W-1];
        flagZ   <= (shaped == '0);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> ($stable(product) && $stable(flagZ) && $stable(flagC))); // R2

  AST_FRAC_LSB_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && fracQ) |=> (product[0] == 1'b0)); // R6

  AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && (aQ == '0 || bQ == '0)) |=> (flagZ && !flagC && product == '0)); // R8

  AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $rose(flagWe)); // R10

endmodule

// File: rtl/mul_unit.sv
module mul_unit
  import mul_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [OP_W-1:0]   opA,
  input  logic [OP_W-1:0]   opB,
  output logic [2*OP_W-1:0] product,
  output logic              flagZ,
  output logic              flagC,
  output logic              flagWe,
  output logic              done
);

  mulStrobes_t strobes;

  mul_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes)
  );

  mul_datapath #(.OP_W(OP_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .mode    (mode),
    .opA     (opA),
    .opB     (opB),
    .product (product),
    .flagZ   (flagZ),
    .flagC   (flagC),
    .flagWe  (flagWe),
    .done    (done)
  );

endmodule

// File: tb/mul_unit_bench.sv
module mul_unit_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  opA = 8'd0;
  logic [7:0]  opB = 8'd0;
  logic [15:0] product;
  logic        flagZ;
  logic        flagC;
  logic        flagWe;
  logic        done;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mul_unit u_mul_unit (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .opA(opA), .opB(opB), .product(product), .flagZ(flagZ),
    .flagC(flagC), .flagWe(flagWe), .done(done)
  );

  // {mode, opA, opB, product, zero, carry}
  localparam int NVEC = 16;
  localparam logic [35:0] VECS [NVEC] = '{
    {2'd0, 8'hFF, 8'hFF, 16'hFE01, 1'b0, 1'b1},  // R3 R7
    {2'd0, 8'h0C, 8'h0A, 16'h0078, 1'b0, 1'b0},  // R3
    {2'd0, 8'h00, 8'h5A, 16'h0000, 1'b1, 1'b0},  // R8
    {2'd1, 8'h80, 8'h80, 16'h4000, 1'b0, 1'b0},  // R4
    {2'd1, 8'hFF, 8'h01, 16'hFFFF, 1'b0, 1'b1},  // R4
    {2'd1, 8'h7F, 8'h81, 16'hC0FF, 1'b0, 1'b1},  // R4
    {2'd1, 8'h02, 8'hFE, 16'hFFFC, 1'b0, 1'b1},  // R4
    {2'd1, 8'h00, 8'h80, 16'h0000, 1'b1, 1'b0},  // R8
    {2'd2, 8'hFF, 8'hFF, 16'hFF01, 1'b0, 1'b1},  // R5
    {2'd2, 8'h7F, 8'hFF, 16'h7E81, 1'b0, 1'b0},  // R5
    {2'd2, 8'h80, 8'h02, 16'hFF00, 1'b0, 1'b1},  // R5
    {2'd2, 8'h02, 8'hFE, 16'h01FC, 1'b0, 1'b0},  // R5
    {2'd3, 8'hFF, 8'hFF, 16'hFC02, 1'b0, 1'b1},  // R6 R7
    {2'd3, 8'h80, 8'h80, 16'h8000, 1'b0, 1'b0},  // R6 R7
    {2'd3, 8'hC0, 8'h02, 16'h0300, 1'b0, 1'b0},  // R6
    {2'd3, 8'h00, 8'h33, 16'h0000, 1'b1, 1'b0}   // R6 R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  // launch at a falling edge, check the busy cycle and the result cycle
  task automatic runOp(input logic [1:0] m, input logic [7:0] a, input logic [7:0] b,
                       input logic [15:0] expP, input logic expZ, input logic expC);
    @(negedge clk);
    start = 1'b1; mode = m; opA = a; opB = b;
    @(negedge clk);
    start = 1'b0; opA = ~a; opB = ~b; mode = ~m;
    check("R1 busy cycle done", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R1 done due", {31'd0, done}, 32'd1);
    check("R10 flagWe with done", {31'd0, flagWe}, 32'd1);
    check("R3/R4/R5/R6 product", {16'd0, product}, {16'd0, expP});
    check("R8 flagZ", {31'd0, flagZ}, {31'd0, expZ});
    check("R7 flagC", {31'd0, flagC}, {31'd0, expC});
    @(negedge clk);
    check("R2 done single cycle", {31'd0, done}, 32'd0);
    check("R10 flagWe low", {31'd0, flagWe}, 32'd0);
    check("R2 product held", {16'd0, product}, {16'd0, expP});
  endtask

  initial begin
    #(4 * 20000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 product in reset", {16'd0, product}, 32'd0);
    check("R11 flags in reset", {29'd0, flagZ, flagC, flagWe}, 32'd0);
    check("R11 done in reset", {31'd0, done}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 idle after reset", {31'd0, done}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      runOp(VECS[i][35:34], VECS[i][33:26], VECS[i][25:18],
            VECS[i][17:2], VECS[i][1], VECS[i][0]);
    end

    // R9: start held through the busy cycle with other operands
    @(negedge clk);
    start = 1'b1; mode = 2'd0; opA = 8'h10; opB = 8'h10;
    @(negedge clk);
    mode = 2'd0; opA = 8'h03; opB = 8'h05;
    check("R9 busy cycle done", {31'd0, done}, 32'd0);
    @(negedge clk);
    start = 1'b0;
    check("R9 first result done", {31'd0, done}, 32'd1);
    check("R9 first operands used", {16'd0, product}, 32'h0100);
    @(negedge clk);
    check("R9 no extra done", {31'd0, done}, 32'd0);
    @(negedge clk);
    check("R9 still no done", {31'd0, done}, 32'd0);
    check("R9 product unchanged", {16'd0, product}, 32'h0100);

    // R2: idle cycles keep results and flags
    repeat (5) @(negedge clk);
    check("R2 held while idle", {14'd0, product, flagZ, flagC}, {14'd0, 16'h0100, 1'b0, 1'b0});

    // back-to-back accepts right after done
    runOp(2'd1, 8'h81, 8'h81, 16'h3F01, 1'b0, 1'b0);
    runOp(2'd0, 8'h00, 8'h00, 16'h0000, 1'b1, 1'b0);

    // R11: reset mid-flight clears outputs
    @(negedge clk);
    start = 1'b1; mode = 2'd0; opA = 8'hFF; opB = 8'hFF;
    @(negedge clk);
    start = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check("R11 async reset outputs", {12'd0, product, flagZ, flagC, flagWe, done}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 no result after reset", {31'd0, done}, 32'd0);

    summary();
  end

endmodule